// File: doc/BRIEF.md
# Firewall Protection Configuration Register Bank

This block is the software-visible configuration store of a security firewall. Secure software reaches it through an APB-style slave port. For each securable peripheral it keeps a 2-bit access attribute, and for each protected on-chip memory zone it keeps a 10-bit size value. Each of these fields has its own lock bit, and once that lock is set the field refuses further changes until the next reset.

The current attributes and zone sizes leave the block as flat vectors, which downstream enforcement logic uses to filter bus traffic. A read-only configuration word reports how many peripherals, memory zones and bus-master zones this instance supports, together with a chunk-size code. A read-only version word reports a fixed revision code.

The peripheral attribute and lock fields are laid out at fixed densities, and software drivers compute field positions from a peripheral's index. Attributes pack sixteen to a word and locks pack thirty-two to a word, so the two kinds live in different register groups.

Top module: `fwcfg_regbank`

## Requirements
- R1: After reset, every attribute, every zone size and every lock bit is zero. `attr_o` and `zone_size_o` read all zeros.
- R2: Zone n has a 32-bit word at byte offset 4*n (n < 4). Bits [9:0] hold the size, bit 31 holds the lock, and all other bits read zero. An accepted write to an unlocked zone changes its `zone_size_o[10*n +: 10]` on the first rising edge after the access phase.
- R3: Writing 1 to bit 31 of a zone word sets that zone's lock. The size carried in that same write is still applied when the zone was unlocked before the write. After that, size writes are ignored, and writing 0 to bit 31 leaves the lock set.
- R4: The attribute of peripheral id is at byte offset 0x010 + 4*(id/16), bits [2*(id%16)+1 : 2*(id%16)]. It also appears on `attr_o[2*id +: 2]` from the edge that accepts the write.
- R5: The lock of peripheral id is at byte offset 0x030 + 4*(id/32), bit id%32. Writing 1 to a bit sets that lock, and writing 0 changes nothing.
- R6: While a peripheral's lock is set, writes to its attribute field are ignored. Unlocked fields in the same word still update from the same write.
- R7: Peripheral ids at or above N_PERIPH and zone indices at or above N_ZONE read as zero and ignore writes.
- R8: The word at 0x3F0 reads {CHUNK[7:0], N_MASTER[7:0], N_PERIPH[7:0], N_ZONE[7:0]}, from bit 31 down to bit 0. Writes to it have no effect.
- R9: The word at 0x3F4 reads REV in bits [7:0] and zero in the bits above. Writes to it have no effect.
- R10: Every other offset reads zero, and a write to one leaves all state and outputs unchanged.
- R11: `pready` is high in every access phase, so each transfer completes in its first access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | AW | Byte address; bits [1:0] are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer completes |
| attr_o | output | 2*N_PERIPH | Current attribute of every peripheral, 2 bits per id |
| zone_size_o | output | 10*N_ZONE | Current size of every zone, 10 bits per zone |

## Verification
The case where two functions share one cycle is a single zone write that carries a new size and also sets bit 31. On that edge the size must be taken and the lock must be set, and every later size write must be refused. The bench provokes this with a directed write of size 0x2AA together with the lock bit. It then checks the output on the next sampling point, tries a second size write and a lock-clearing write, and reads the word back. In the same way, an attribute word write that hits both locked and unlocked fields must update only the unlocked ones. The bench judges this against its own model, in both the directed steps and the random traffic.

// File: rtl/fwcfg_regbank.sv
module fwcfg_regbank #(
  parameter int          N_PERIPH = 40,
  parameter int          N_ZONE   = 2,
  parameter int          N_MASTER = 3,
  parameter logic [7:0]  CHUNK    = 8'h01,
  parameter logic [7:0]  REV      = 8'h02,
  parameter int          AW       = 12
) (
  input  logic                    pclk,
  input  logic                    presetn,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [AW-1:0]           paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    pready,
  output logic [2*N_PERIPH-1:0]   attr_o,
  output logic [10*N_ZONE-1:0]    zone_size_o
);

  localparam int WW      = AW - 2;
  localparam int ZSZ_W   = 10;
  localparam int ATTR_W0 = 4;
  localparam int LOCK_W0 = 12;
  localparam int UNMAP_W = 16;
  localparam int HW_W    = 252;
  localparam int VER_W   = 253;
  localparam logic [31:0] HWCFG = {CHUNK, 8'(N_MASTER), 8'(N_PERIPH), 8'(N_ZONE)};

  logic [WW-1:0] word;
  logic          wr_en;
  logic [1:0]    attr_q [N_PERIPH];
  logic          plk_q  [N_PERIPH];
  logic [ZSZ_W-1:0] zsz_q [N_ZONE];
  logic          zlk_q  [N_ZONE];
  logic [255:0]  attr_pad;
  logic [127:0]  lock_pad;
  logic [31:0]   zone_rd [4];
  logic [2:0]    aidx;
  logic [1:0]    lidx;

  assign word   = paddr[AW-1:2];
  assign wr_en  = psel & penable & pwrite;
  assign pready = 1'b1;
  assign aidx   = 3'(word - WW'(ATTR_W0));
  assign lidx   = 2'(word - WW'(LOCK_W0));

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
    localparam int AWD = ATTR_W0 + i / 16;
    localparam int AB  = 2 * (i % 16);
    localparam int LWD = LOCK_W0 + i / 32;
    localparam int LB  = i % 32;
    logic hit_a, hit_l;
    assign hit_a = wr_en && (word == WW'(AWD));
    assign hit_l = wr_en && (word == WW'(LWD));

    always_ff @(posedge pclk) begin
      if (!presetn) begin
        attr_q[i] <= 2'b00;
        plk_q[i]  <= 1'b0;
      end else begin
        if (hit_a && !plk_q[i]) attr_q[i] <= pwdata[AB +: 2];
        if (hit_l && pwdata[LB]) plk_q[i] <= 1'b1;
      end
    end

    assign attr_o[2*i +: 2] = attr_q[i];

    // R5
    plk_sticky_chk: assert property (@(posedge pclk) disable iff (!presetn)
      plk_q[i] |=> plk_q[i]);
    // R6
    plk_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      plk_q[i] |=> $stable(attr_o[2*i +: 2]));
  end

  for (genvar n = 0; n < N_ZONE; n++) begin : g_zone
    logic hit_z;
    assign hit_z = wr_en && (word == WW'(n));

    always_ff @(posedge pclk) begin
      if (!presetn) begin
        zsz_q[n] <= '0;
        zlk_q[n] <= 1'b0;
      end else begin
        if (hit_z && !zlk_q[n]) zsz_q[n] <= pwdata[ZSZ_W-1:0];
        if (hit_z && pwdata[31]) zlk_q[n] <= 1'b1;
      end
    end

    assign zone_size_o[ZSZ_W*n +: ZSZ_W] = zsz_q[n];

    // R3
    zlk_sticky_chk: assert property (@(posedge pclk) disable iff (!presetn)
      zlk_q[n] |=> zlk_q[n]);
    // R3
    zlk_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      zlk_q[n] |=> $stable(zone_size_o[ZSZ_W*n +: ZSZ_W]));
  end

  always_comb begin
    attr_pad = '0;
    lock_pad = '0;
    for (int i = 0; i < N_PERIPH; i++) begin
      attr_pad[2*i +: 2] = attr_q[i];
      lock_pad[i]        = plk_q[i];
    end
  end

  always_comb begin
    for (int z = 0; z < 4; z++) zone_rd[z] = '0;
    for (int z = 0; z < N_ZONE; z++)
      zone_rd[z] = {zlk_q[z], 21'd0, zsz_q[z]};
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (word < WW'(ATTR_W0))       prdata = zone_rd[word[1:0]];
      else if (word < WW'(LOCK_W0))  prdata = attr_pad[32*aidx +: 32];
      else if (word < WW'(UNMAP_W))  prdata = lock_pad[32*lidx +: 32];
      else if (word == WW'(HW_W))    prdata = HWCFG;
      else if (word == WW'(VER_W))   prdata = {24'd0, REV};
    end
  end

  // R10
  unmapped_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && word >= WW'(UNMAP_W)) |=> ($stable(attr_o) && $stable(zone_size_o)));
  // R1
  reset_clear_chk: assert property (@(posedge pclk)
    !presetn |=> (attr_o == '0 && zone_size_o == '0));

endmodule

// File: tb/fwcfg_regbank_tb.sv
module fwcfg_regbank_tb;
  localparam int NP = 40;
  localparam int NZ = 2;

  logic clk = 1'b0;
  logic rstn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;
  logic [2*NP-1:0] attr_o;
  logic [10*NZ-1:0] zone_size_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [1:0] m_attr [NP];
  logic       m_plk  [NP];
  logic [9:0] m_zsz  [NZ];
  logic       m_zlk  [NZ];

  always #5 clk = ~clk;

  fwcfg_regbank u_dut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .attr_o(attr_o), .zone_size_o(zone_size_o));

  function automatic string req_of(logic [11:0] a);
    int w = int'(a[11:2]);
    if (w < 4) return (w < NZ) ? "R2/R3" : "R7";
    if (w < 12) return "R4/R6/R7";
    if (w < 16) return "R5/R7";
    if (w == 252) return "R8";
    if (w == 253) return "R9";
    return "R10";
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    int w = int'(a[11:2]);
    logic [31:0] r = '0;
    if (w < 4) begin
      if (w < NZ) r = {m_zlk[w], 21'd0, m_zsz[w]};
    end else if (w < 12) begin
      for (int f = 0; f < 16; f++)
        if ((w-4)*16+f < NP) r[2*f +: 2] = m_attr[(w-4)*16+f];
    end else if (w < 16) begin
      for (int b = 0; b < 32; b++)
        if ((w-12)*32+b < NP) r[b] = m_plk[(w-12)*32+b];
    end else if (w == 252) r = {8'h01, 8'd3, 8'd40, 8'd2};
    else if (w == 253) r = 32'h0000_0002;
    return r;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    int w = int'(a[11:2]);
    if (w < NZ) begin
      if (!m_zlk[w]) m_zsz[w] = d[9:0];
      if (d[31]) m_zlk[w] = 1'b1;
    end else if (w >= 4 && w < 12) begin
      for (int f = 0; f < 16; f++) begin
        int id = (w-4)*16+f;
        if (id < NP && !m_plk[id]) m_attr[id] = d[2*f +: 2];
      end
    end else if (w >= 12 && w < 16) begin
      for (int b = 0; b < 32; b++) begin
        int id = (w-12)*32+b;
        if (id < NP && d[b]) m_plk[id] = 1'b1;
      end
    end
  endtask

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    logic [2*NP-1:0] ea;
    logic [10*NZ-1:0] ez;
    for (int i = 0; i < NP; i++) ea[2*i +: 2] = m_attr[i];
    for (int z = 0; z < NZ; z++) ez[10*z +: 10] = m_zsz[z];
    chk({req, " attr_o"}, 128'(attr_o), 128'(ea));
    chk({req, " zone_size_o"}, 128'(zone_size_o), 128'(ez));
  endtask

  task automatic apb_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1 chk("R11 pready", 128'(pready), 128'(1));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    model_write(a, d);
  endtask

  task automatic apb_read(logic [11:0] a, string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk({req, " read"}, 128'(prdata), 128'(exp_read(a)));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) begin m_attr[i] = '0; m_plk[i] = 0; end
    for (int z = 0; z < NZ; z++) begin m_zsz[z] = '0; m_zlk[z] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstn = 1'b1;

    // R1 reset state
    check_outs("R1");
    apb_read(12'h000, "R1"); apb_read(12'h010, "R1"); apb_read(12'h030, "R1");
    // R8 / R9 read-only words
    apb_read(12'h3F0, "R8");
    apb_write(12'h3F0, 32'hFFFF_FFFF); apb_read(12'h3F0, "R8"); check_outs("R8");
    apb_read(12'h3F4, "R9");
    apb_write(12'h3F4, 32'h1234_5678); apb_read(12'h3F4, "R9");
    // R2 zone size
    apb_write(12'h000, 32'h7FFF_F155); check_outs("R2"); apb_read(12'h000, "R2");
    // R3 size and lock in one write, then refused writes
    apb_write(12'h004, 32'h8000_02AA); check_outs("R3");
    chk("R3 same-write size", 128'(zone_size_o[19:10]), 128'(10'h2AA));
    apb_write(12'h004, 32'h0000_0011); check_outs("R3");
    apb_read(12'h004, "R3");
    chk("R3 lock held", 128'(exp_read(12'h004) >> 31), 128'(1));
    // R4 attribute field placement
    apb_write(12'h010, 32'hE400_001B); check_outs("R4");
    chk("R4 id0", 128'(attr_o[1:0]), 128'(2'b11));
    chk("R4 id15", 128'(attr_o[31:30]), 128'(2'b11));
    apb_read(12'h010, "R4");
    // R5 write-one-to-set
    apb_write(12'h030, 32'h0000_0008); apb_read(12'h030, "R5");
    apb_write(12'h030, 32'h0000_0000); apb_read(12'h030, "R5");
    // R6 locked neighbour holds, others update
    apb_write(12'h010, 32'h0000_0000); check_outs("R6");
    chk("R6 id3 held", 128'(attr_o[7:6]), 128'(2'b00));
    apb_write(12'h010, 32'hFFFF_FFFF); check_outs("R6");
    chk("R6 id3 locked", 128'(attr_o[7:6]), 128'(2'b00));
    chk("R6 id2 free", 128'(attr_o[5:4]), 128'(2'b11));
    // R7 out-of-range ids and zones
    apb_write(12'h018, 32'hFFFF_FFFF); apb_read(12'h018, "R7");
    apb_write(12'h01C, 32'hFFFF_FFFF); apb_read(12'h01C, "R7");
    apb_write(12'h034, 32'hFFFF_FFFF); apb_read(12'h034, "R7");
    apb_write(12'h008, 32'h8000_03FF); apb_read(12'h008, "R7"); check_outs("R7");
    // R10 unmapped
    apb_write(12'h100, 32'hFFFF_FFFF); apb_read(12'h100, "R10"); check_outs("R10");
    apb_read(12'h03C, "R10");

    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1:    a = 12'($urandom_range(0, 3) * 4);
        2, 3, 4: a = 12'(16 + $urandom_range(0, 7) * 4);
        5:       a = 12'(48 + $urandom_range(0, 3) * 4);
        6:       a = ($urandom_range(0, 1) != 0) ? 12'h3F0 : 12'h3F4;
        default: a = 12'($urandom_range(0, 4095)) & 12'hFFC;
      endcase
      d = $urandom();
      if (a[11:2] >= 12 && a[11:2] < 16) d = d & $urandom() & $urandom() & $urandom();
      if (a[11:2] < 4 && $urandom_range(0, 7) != 0) d[31] = 1'b0;
      if ($urandom_range(0, 1) != 0) begin
        apb_write(a, d);
        check_outs(req_of(a));
      end else begin
        apb_read(a, req_of(a));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule